// File: doc/BRIEF.md
# Masked Serial Command Shifter

This block drives a three-wire synchronous serial bus (clock, data, enable) that carries short commands to peripheral devices. The CPU loads two 16-bit registers: a selection mask and a command word. Writing the command word starts a transfer. The block steps through all sixteen register positions, most significant first, and spends one bit period on each. In every position whose mask bit is set, it places the command bit on the data line and gives one clock pulse. Positions with a clear mask bit use their bit period but put nothing on the bus. A command can therefore be laid out in any set of positions. A typical layout is an address field, an optional gap of unused positions, and then a data field. For example, a mask of 0x07FF sends eleven bits: a 2-bit address followed by 9 data bits.

During a transfer both registers rotate left by one position per bit period, and the CPU reads these rotating contents. After the sixteenth step both registers hold their original values again. Software can therefore tell that a transfer has finished when the readback matches what it wrote, or it can watch the busy output. The mask stays in place, so a series of commands needs only one mask write.

Top module: `mws_cmd_shifter`

## Requirements
- R1: After reset, both registers read 0, and busy, serial clock, serial data and enable are all low.
- R2: A mask write (select = 1) while idle loads the mask readback on the next cycle and does not start a transfer (busy stays low).
- R3: A command write (select = 0) while idle starts a transfer. Busy stays high for exactly 16 bit periods, which is 32*HALF_CYC clock cycles.
- R4: The bits of the masked positions are sent most significant position first, one clock pulse per set mask bit. Unmasked positions produce no pulse. Each bit is valid on the data line at the rising edge of the serial clock.
- R5: The serial clock is high only in the second half of a masked bit period. The data line changes only while the serial clock is low.
- R6: Enable is high, without a break, from the start of the bit period of the highest set mask bit to the end of the bit period of the lowest set mask bit. It is never high while idle. The serial clock is high only while enable is high.
- R7: During a transfer, after j completed bit periods, the data and mask readbacks equal the values written, rotated left by j positions.
- R8: When busy falls, both readbacks equal their values at the start. The retained mask serves the next command without being rewritten.
- R9: Writes to either register while busy is high are ignored. This includes a write in the cycle that completes the sixteenth rotation.
- R10: With a mask of zero, a command write still holds busy for the full 16 bit periods, but produces no clock pulse and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = command word, 1 = mask |
| wr_val_i | input | 16 | Value to write |
| rd_data_o | output | 16 | Live command-word register contents |
| rd_mask_o | output | 16 | Live mask register contents |
| busy_o | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock; devices sample on its rising edge |
| sdo_o | output | 1 | Serial data |
| cs_o | output | 1 | Active-high device enable |

## Verification
The closest collision is between a CPU write and the step that ends a transfer. The last bit period ends and the sixteenth rotation restores the registers on the same edge that a new write may arrive. The bench presents a mask or command write exactly on that final edge. It then checks that busy is low, that both readbacks still show the original values, and that no new transfer has started. The next write, one cycle later, must then be accepted. A second collision, between a masked bit ending and the rotation bringing in the next position, is covered by mask patterns with gaps and with bits at both ends. For these the bench counts enable-high cycles against the span from the highest to the lowest set mask bit.

// File: rtl/mws_pkg.sv
package mws_pkg;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_MASK = 1'b1
    } mws_sel_e;

endpackage

// File: rtl/mws_bit_timer.sv
module mws_bit_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    output logic phase_hi_o,
    output logic bit_end_o
);
    localparam int PER_CYC = 2 * HALF_CYC;
    localparam int TW      = (PER_CYC > 1) ? $clog2(PER_CYC) : 1;

    logic [TW-1:0] count_d, count_q;

    assign bit_end_o  = run_i && (count_q == TW'(PER_CYC - 1));
    assign phase_hi_o = (count_q >= TW'(HALF_CYC));

    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (run_i) begin
            count_d = bit_end_o ? '0 : count_q + TW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end
endmodule

// File: rtl/mws_popcount.sv
module mws_popcount #(
    parameter int W = 16
) (
    input  logic [W-1:0]           vec_i,
    output logic [$clog2(W+1)-1:0] cnt_o
);
    localparam int CW = $clog2(W + 1);

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/mws_cmd_shifter.sv
module mws_cmd_shifter
    import mws_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int HALF_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_val_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [REG_W-1:0] rd_mask_o,
    output logic             busy_o,
    output logic             sclk_o,
    output logic             sdo_o,
    output logic             cs_o
);
    localparam int MSB    = REG_W - 1;
    localparam int STEP_W = $clog2(REG_W);
    localparam int CNT_W  = $clog2(REG_W + 1);

    typedef struct packed {
        logic [REG_W-1:0]  data;
        logic [REG_W-1:0]  mask;
        logic              busy;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  left;
        logic              seen;
    } shf_state_t;

    shf_state_t st_d, st_q;

    logic             phase_hi, bit_end;
    logic             accept, start;
    logic [CNT_W-1:0] mask_ones;
    logic             cur_live;

    assign accept = wr_en_i && !st_q.busy;
    assign start  = accept && (wr_sel_i == SEL_DATA);

    mws_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (st_q.busy),
        .clear_i    (start),
        .phase_hi_o (phase_hi),
        .bit_end_o  (bit_end)
    );

    mws_popcount #(.W(REG_W)) u_ones (
        .vec_i (st_q.mask),
        .cnt_o (mask_ones)
    );

    always_comb begin
        st_d = st_q;
        if (accept && (wr_sel_i == SEL_MASK)) begin
            st_d.mask = wr_val_i;
        end
        if (start) begin
            st_d.data = wr_val_i;
            st_d.busy = 1'b1;
            st_d.step = '0;
            st_d.left = mask_ones;
            st_d.seen = 1'b0;
        end
        if (st_q.busy && bit_end) begin
            st_d.data = {st_q.data[MSB-1:0], st_q.data[MSB]};
            st_d.mask = {st_q.mask[MSB-1:0], st_q.mask[MSB]};
            st_d.step = st_q.step + STEP_W'(1);
            if (st_q.mask[MSB]) begin
                st_d.left = st_q.left - CNT_W'(1);
                st_d.seen = 1'b1;
            end
            if (st_q.step == STEP_W'(REG_W - 1)) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_live  = st_q.busy && st_q.mask[MSB];
    assign rd_data_o = st_q.data;
    assign rd_mask_o = st_q.mask;
    assign busy_o    = st_q.busy;
    assign sclk_o    = cur_live && phase_hi;
    assign sdo_o     = cur_live && st_q.data[MSB];
    assign cs_o      = st_q.busy && (st_q.left != '0) && (st_q.seen || st_q.mask[MSB]);
endmodule

// File: rtl/mws_checks.sv
module mws_checks #(
    parameter int REG_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [REG_W-1:0] wr_val_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic [REG_W-1:0] rd_mask_o,
    input logic             busy_o,
    input logic             sclk_o,
    input logic             sdo_o,
    input logic             cs_o
);
    logic [REG_W-1:0] snap_data_q, snap_mask_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            snap_data_q <= '0;
            snap_mask_q <= '0;
        end else if (wr_en_i && !wr_sel_i && !busy_o) begin
            snap_data_q <= wr_val_i;
            snap_mask_q <= rd_mask_o;
        end
    end

    assert_start_by_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(wr_en_i && !wr_sel_i));

    assert_idle_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !wr_en_i) |=> $stable(rd_mask_o));

    assert_sdo_clock_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sdo_o) |-> !sclk_o);

    assert_cs_in_transfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_o |-> busy_o);

    assert_sclk_needs_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> cs_o);

    assert_restore_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (rd_data_o == snap_data_q));

    assert_restore_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (rd_mask_o == snap_mask_q));
endmodule

bind mws_cmd_shifter mws_checks #(.REG_W(REG_W)) u_checks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_val_i  (wr_val_i),
    .rd_data_o (rd_data_o),
    .rd_mask_o (rd_mask_o),
    .busy_o    (busy_o),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .cs_o      (cs_o)
);

// File: tb/mws_cmd_shifter_tb.sv
module mws_cmd_shifter_tb;
    localparam int W    = 16;
    localparam int H    = 4;
    localparam int XFER = 32 * H;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_val = '0;
    logic [W-1:0] rd_data, rd_mask;
    logic         busy, sclk, sdo, cs;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] cap_bits;
    int           cap_n;
    logic         cap_on = 1'b0;

    always #2 clk = ~clk;

    mws_cmd_shifter #(.REG_W(W), .HALF_CYC(H)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_val_i(wr_val), .rd_data_o(rd_data), .rd_mask_o(rd_mask),
        .busy_o(busy), .sclk_o(sclk), .sdo_o(sdo), .cs_o(cs)
    );

    always @(posedge sclk) begin
        if (cap_on) begin
            cap_bits = {cap_bits[W-2:0], sdo};
            cap_n    = cap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int n);
        logic [W-1:0] r = v;
        for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
        return r;
    endfunction

    task automatic cpu_write(input logic sel, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_val = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cmd(input logic [W-1:0] m, input logic [W-1:0] d, input string tag);
        logic [W-1:0] exp_bits = '0;
        int exp_n = 0, hi = -1, lo = -1;
        int cs_cyc = 0, cs_rise = 0, bad_sdo = 0, busy_cyc = 0;
        logic prev_cs = 1'b0, prev_sdo;
        for (int i = W - 1; i >= 0; i--) begin
            if (m[i]) begin
                exp_bits = {exp_bits[W-2:0], d[i]};
                exp_n++;
                if (hi < 0) hi = i;
                lo = i;
            end
        end
        cap_bits = '0; cap_n = 0; cap_on = 1'b1;
        cpu_write(1'b0, d);
        prev_sdo = sdo;
        for (int n = 0; n < XFER + 4; n++) begin
            if (busy) busy_cyc++;
            if (cs) cs_cyc++;
            if (cs && !prev_cs) cs_rise++;
            if (sdo !== prev_sdo && sclk) bad_sdo++;
            prev_cs = cs; prev_sdo = sdo;
            @(negedge clk);
        end
        cap_on = 1'b0;
        chk({"R3 busy duration ", tag}, busy_cyc, XFER);
        chk({"R4 pulse count ", tag}, cap_n, exp_n);
        chk({"R4 bit order ", tag}, cap_bits, exp_bits);
        chk({"R5 sdo stable while sclk high ", tag}, bad_sdo, 0);
        chk({"R6 enable span ", tag}, cs_cyc, (hi < 0) ? 0 : (hi - lo + 1) * 2 * H);
        chk({"R6 single enable window ", tag}, cs_rise, (hi < 0) ? 0 : 1);
        chk({"R8 data restored ", tag}, rd_data, d);
        chk({"R8 mask restored ", tag}, rd_mask, m);
    endtask

    task automatic t_reset();
        chk("R1 data reset", rd_data, 0);
        chk("R1 mask reset", rd_mask, 0);
        chk("R1 outputs low", {busy, sclk, sdo, cs}, 0);
    endtask

    task automatic t_mask_write();
        cpu_write(1'b1, 16'h07FF);
        chk("R2 mask loaded", rd_mask, 16'h07FF);
        chk("R2 no transfer", busy, 0);
        repeat (3) @(negedge clk);
        chk("R2 still idle", {busy, cs, sclk}, 0);
    endtask

    task automatic t_snapshot(input logic [W-1:0] m, input logic [W-1:0] d);
        cpu_write(1'b1, m);
        cpu_write(1'b0, d);
        repeat (2 * H * 5) @(negedge clk);
        chk("R7 data after 5 steps", rd_data, rotl(d, 5));
        chk("R7 mask after 5 steps", rd_mask, rotl(m, 5));
        repeat (2 * H * 6 - 1) @(negedge clk);
        chk("R7 data before step 11", rd_data, rotl(d, 10));
        @(negedge clk);
        chk("R7 data after 11 steps", rd_data, rotl(d, 11));
        repeat (XFER) @(negedge clk);
    endtask

    task automatic t_busy_block();
        cpu_write(1'b1, 16'hF00F);
        cpu_write(1'b0, 16'h1234);
        repeat (20) @(negedge clk);
        cpu_write(1'b1, 16'h0000);
        cpu_write(1'b0, 16'hFFFF);
        // two writes used 4 negedges after the 20, total 22+2 since start edge
        repeat (XFER - 1 - 24) @(negedge clk);
        chk("R9 busy just before end", busy, 1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_val = 16'hBEEF;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 final-edge write ignored busy", busy, 0);
        chk("R9 final-edge write ignored data", rd_data, 16'h1234);
        chk("R9 mid-transfer mask write ignored", rd_mask, 16'hF00F);
        cpu_write(1'b0, 16'hBEEF);
        chk("R9 next write accepted", {busy, rd_data}, {1'b1, 16'hBEEF});
        repeat (XFER) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_write();
        run_cmd(16'h07FF, 16'h04D4, "addr+data");
        run_cmd(16'h07FF, 16'hF92B, "mask reused R8");
        cpu_write(1'b1, 16'hC001);
        run_cmd(16'hC001, 16'h5AA5, "split fields");
        cpu_write(1'b1, 16'h0C10);
        run_cmd(16'h0C10, 16'hFFFF, "gap ones");
        cpu_write(1'b1, 16'hFFFF);
        run_cmd(16'hFFFF, 16'hA5C3, "full");
        cpu_write(1'b1, 16'h0000);
        run_cmd(16'h0000, 16'hFFFF, "empty mask R10");
        t_snapshot(16'h8421, 16'h3C5A);
        t_busy_block();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule